// File: doc/BRIEF.md
# Power-Fail Save and Restore Sequencer

This block supervises a non-volatile shadow memory that has no battery. It reads two digital supply flags from external comparators. One flag means the supply is below the switch threshold. The other means the supply is below the deeper reset threshold. From these flags it sequences the transfers between the working RAM and the non-volatile array. It drives no data itself. It raises request strobes, which the storage logic acknowledges with done pulses. It also drives inhibits that stop the RAM port from being used while a transfer runs or while the supply is weak.

When the supply falls through the switch level with automatic saving enabled, the block pulls an open-drain busy line low for a fixed pulse. It starts a save only if the RAM has been written since the last non-volatile cycle and the busy line really went low. It latches a restore whenever the supply drops below the reset level, including at first power-up. The restore runs once the supply is back above the switch level: one clear cycle, then a copy phase. Both supply flags pass through a two-stage synchroniser before the state machine uses them.

States: `S_LOW` (supply weak, waiting for recovery), `S_IDLE` (normal operation), `S_PULSE` (busy pulse on a falling supply), `S_SAVE` (save running), `S_CLEAR` (RAM clear cycle of a restore), `S_COPY` (non-volatile data copied into RAM). The transitions are:

- Reset goes to `S_LOW` with a restore pending.
- `S_LOW` goes to `S_CLEAR` when the supply recovers and a restore is pending, otherwise to `S_IDLE`.
- `S_IDLE` goes to `S_PULSE` on a falling supply, or to `S_LOW` when automatic saving is off.
- `S_IDLE` goes to `S_SAVE` on an explicit request while the RAM is dirty.
- `S_PULSE` goes to `S_SAVE` when dirty and the busy line went low, otherwise to `S_LOW`.
- `S_SAVE` goes to `S_LOW` or `S_IDLE` on done or timeout.
- `S_CLEAR` always goes to `S_COPY`.
- `S_COPY` goes to `S_IDLE` or `S_LOW` on done or timeout.

Top module: `pfs_seq`

## Requirements
- R1: After reset, a restore is pending. Once the synchronised supply is above the switch level, the block asserts `ram_clear_o` and then `restore_req_o`. `access_inhibit_o` is high throughout.
- R2: A restore asserts `ram_clear_o` for exactly one cycle. It then holds `restore_req_o` until `restore_done_i` or for RESTORE_MAX cycles, whichever comes first.
- R3: A restore is latched only when `below_rst_i` (1 = below reset level) is seen high. A dip below the switch level alone never causes a restore.
- R4: With `auto_off_i` = 0, a falling supply drives `busy_pull_o` (1 = pull line low) for exactly PULSE_CYC cycles. If the RAM is clean, no save follows.
- R5: If the RAM is dirty, a save follows the pulse. `busy_pull_o` stays high for the whole save. `save_req_o` ends on `save_done_i` or after SAVE_MAX cycles.
- R6: `write_inhibit_o` is high while the synchronised supply is below the switch level and in every state other than idle. A write strobe seen while the inhibit is high does not make the RAM dirty.
- R7: `ext_save_i` starts a save only from idle, with the supply good and the RAM dirty. It is ignored while the supply is low.
- R8: If `busy_sense_i` (1 = line high) is still 1 on the last pulse cycle, the save attempt is abandoned.
- R9: With `auto_off_i` = 1, a falling supply produces neither a busy pulse nor a save.
- R10: Completing a save or a restore clears the dirty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| below_sw_i | input | 1 | Supply below switch level (asynchronous) |
| below_rst_i | input | 1 | Supply below reset level (asynchronous) |
| auto_off_i | input | 1 | 1 disables automatic save on power loss |
| ram_wr_i | input | 1 | RAM write strobe from the access port |
| ext_save_i | input | 1 | Explicit save request |
| busy_sense_i | input | 1 | Sensed level of the open-drain busy line |
| save_done_i | input | 1 | Storage reports save complete |
| restore_done_i | input | 1 | Storage reports restore complete |
| save_req_o | output | 1 | Save request to storage |
| ram_clear_o | output | 1 | Clear phase of a restore |
| restore_req_o | output | 1 | Copy phase of a restore |
| write_inhibit_o | output | 1 | Blocks RAM writes |
| access_inhibit_o | output | 1 | Blocks all RAM access during transfers |
| busy_pull_o | output | 1 | 1 = pull busy line low |

## Verification
On every cycle, the assertions check the following:

- The clear cycle is single and is always followed by the copy phase.
- At most one transfer strobe is high at a time.
- A save never runs without busy being pulled.
- A write cannot dirty the RAM while the supply is low.
- A finished save leaves the RAM clean.
- A restore starts only when one is pending.
- A pulse that sees the line stay high never leads to a save.

Only the bench scenarios can show the rest:

- that a shallow dip restores nothing;
- that pulse, save and restore lengths match the parameters;
- that a restore cleans the RAM;
- that explicit requests are gated by supply and by dirtiness;
- that disabling automatic saving suppresses the whole power-loss sequence.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [2:0] {
        S_LOW   = 3'd0,
        S_IDLE  = 3'd1,
        S_PULSE = 3'd2,
        S_SAVE  = 3'd3,
        S_CLEAR = 3'd4,
        S_COPY  = 3'd5
    } pfs_state_t;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pfs_timer.sv
module pfs_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pfs_flag.sv
module pfs_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= RST_VAL;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq #(
    parameter int PULSE_CYC   = 50,
    parameter int SAVE_MAX    = 500000,
    parameter int RESTORE_MAX = 27500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_sw_i,
    input  logic below_rst_i,
    input  logic auto_off_i,
    input  logic ram_wr_i,
    input  logic ext_save_i,
    input  logic busy_sense_i,
    input  logic save_done_i,
    input  logic restore_done_i,
    output logic save_req_o,
    output logic ram_clear_o,
    output logic restore_req_o,
    output logic write_inhibit_o,
    output logic access_inhibit_o,
    output logic busy_pull_o
);
    import pfs_pkg::*;

    localparam int MAX_A = (SAVE_MAX > RESTORE_MAX) ? SAVE_MAX : RESTORE_MAX;
    localparam int MAX_C = (MAX_A > PULSE_CYC) ? MAX_A : PULSE_CYC;
    localparam int TW    = $clog2(MAX_C + 1);

    pfs_state_t    state, state_n;
    logic          sw_low, rst_low;
    logic [1:0]    flags_s;
    logic          tload, tzero;
    logic [TW-1:0] tval;
    logic          dirty, dirty_set, dirty_clr;
    logic          rest_pend, pend_clr;

    pfs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({below_rst_i, below_sw_i}), .q(flags_s)
    );
    assign sw_low  = flags_s[0];
    assign rst_low = flags_s[1];

    pfs_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tload), .val(tval), .zero(tzero)
    );

    assign dirty_set = ram_wr_i && !write_inhibit_o;
    pfs_flag #(.RST_VAL(1'b0)) u_dirty (
        .clk(clk), .rst_n(rst_n), .set(dirty_set), .clr(dirty_clr), .q(dirty)
    );

    pfs_flag #(.RST_VAL(1'b1)) u_pend (
        .clk(clk), .rst_n(rst_n), .set(rst_low), .clr(pend_clr), .q(rest_pend)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_LOW;
        else        state <= state_n;
    end

    // next state, timer loads and flag clears
    always_comb begin
        state_n   = state;
        tload     = 1'b0;
        tval      = '0;
        dirty_clr = 1'b0;
        pend_clr  = 1'b0;
        unique case (state)
            S_LOW: begin
                if (!sw_low) state_n = rest_pend ? S_CLEAR : S_IDLE;
            end
            S_IDLE: begin
                if (sw_low) begin
                    if (auto_off_i) begin
                        state_n = S_LOW;
                    end else begin
                        state_n = S_PULSE;
                        tload   = 1'b1;
                        tval    = TW'(PULSE_CYC - 1);
                    end
                end else if (ext_save_i && dirty) begin
                    state_n = S_SAVE;
                    tload   = 1'b1;
                    tval    = TW'(SAVE_MAX - 1);
                end
            end
            S_PULSE: begin
                if (tzero) begin
                    if (!busy_sense_i && dirty) begin
                        state_n = S_SAVE;
                        tload   = 1'b1;
                        tval    = TW'(SAVE_MAX - 1);
                    end else begin
                        state_n = S_LOW;
                    end
                end
            end
            S_SAVE: begin
                if (save_done_i || tzero) begin
                    state_n   = sw_low ? S_LOW : S_IDLE;
                    dirty_clr = 1'b1;
                end
            end
            S_CLEAR: begin
                state_n = S_COPY;
                tload   = 1'b1;
                tval    = TW'(RESTORE_MAX - 1);
            end
            S_COPY: begin
                if (restore_done_i || tzero) begin
                    state_n   = sw_low ? S_LOW : S_IDLE;
                    dirty_clr = 1'b1;
                    pend_clr  = 1'b1;
                end
            end
            default: state_n = S_LOW;
        endcase
    end

    // outputs
    always_comb begin
        save_req_o       = (state == S_SAVE);
        ram_clear_o      = (state == S_CLEAR);
        restore_req_o    = (state == S_COPY);
        busy_pull_o      = (state == S_PULSE) || (state == S_SAVE);
        access_inhibit_o = (state == S_SAVE) || (state == S_CLEAR) || (state == S_COPY);
        write_inhibit_o  = sw_low || (state != S_IDLE);
    end

    a_r2_clear_then_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_clear_o |=> (restore_req_o && !ram_clear_o));
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req_o, ram_clear_o, restore_req_o}));
    a_r5_save_busy: assert property (@(posedge clk) disable iff (!rst_n)
        save_req_o |-> busy_pull_o);
    a_r6_no_dirty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_low && !dirty) |=> !dirty);
    a_r10_clean_after_save: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(save_req_o) |-> !dirty);
    a_r3_restore_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_clear_o) |-> $past(rest_pend));
    a_r8_abandon: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PULSE && tzero && busy_sense_i) |=> !save_req_o);
endmodule

// File: tb/pfs_seq_tb.sv
module pfs_seq_tb;
    localparam int PULSE = 6;
    localparam int SMAX  = 40;
    localparam int RMAX  = 30;
    localparam int EV_BUSY = 0, EV_SAVE = 1, EV_CLEAR = 2, EV_COPY = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic below_sw = 1'b1, below_rst = 1'b1, auto_off = 1'b0;
    logic ram_wr = 1'b0, ext_save = 1'b0, save_done = 1'b0, restore_done = 1'b0;
    logic force_hi = 1'b0;
    logic busy_sense;
    logic save_req, ram_clear, restore_req, wr_inh, acc_inh, busy_pull;

    int checks = 0;
    int fails  = 0;

    typedef struct { int ev; string req; } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    assign busy_sense = force_hi ? 1'b1 : !busy_pull;

    pfs_seq #(.PULSE_CYC(PULSE), .SAVE_MAX(SMAX), .RESTORE_MAX(RMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .below_sw_i(below_sw), .below_rst_i(below_rst),
        .auto_off_i(auto_off), .ram_wr_i(ram_wr), .ext_save_i(ext_save),
        .busy_sense_i(busy_sense), .save_done_i(save_done),
        .restore_done_i(restore_done), .save_req_o(save_req),
        .ram_clear_o(ram_clear), .restore_req_o(restore_req),
        .write_inhibit_o(wr_inh), .access_inhibit_o(acc_inh),
        .busy_pull_o(busy_pull)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int ev, input string req);
        exp_t e;
        e.ev = ev;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic seen_ev(input int ev);
        exp_t e;
        if (q.size() == 0) begin
            chk(1'b0, "R3/R4/R9", "unexpected event", ev, -1);
        end else begin
            e = q.pop_front();
            chk(e.ev == ev, e.req, "event order", ev, e.ev);
        end
    endtask

    // monitor: detect rising strobes and compare against the expected queue
    logic p_busy = 1'b0, p_save = 1'b0, p_clr = 1'b0, p_copy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_pull && !p_busy)     seen_ev(EV_BUSY);
            if (save_req && !p_save)      seen_ev(EV_SAVE);
            if (ram_clear && !p_clr)      seen_ev(EV_CLEAR);
            if (restore_req && !p_copy)   seen_ev(EV_COPY);
        end
        p_busy = busy_pull;
        p_save = save_req;
        p_clr  = ram_clear;
        p_copy = restore_req;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wr();
        ram_wr = 1'b1; cyc(1); ram_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int n;
        cyc(3);
        // reset state
        chk(!save_req && !restore_req && !busy_pull, "R1", "reset strobes", save_req, 0);
        chk(wr_inh == 1'b1, "R6", "reset write inhibit", wr_inh, 1);
        rst_n = 1'b1;
        cyc(4);
        chk(!ram_clear && !restore_req, "R1", "no restore while low", restore_req, 0);

        // first power-up restore (R1, R2)
        expect_ev(EV_CLEAR, "R1");
        expect_ev(EV_COPY, "R2");
        below_rst = 1'b0;
        below_sw  = 1'b0;
        while (!restore_req) cyc(1);
        chk(acc_inh == 1'b1, "R1", "access inhibit in restore", acc_inh, 1);
        chk(wr_inh == 1'b1, "R6", "write inhibit in restore", wr_inh, 1);
        cyc(3);
        restore_done = 1'b1; cyc(1); restore_done = 1'b0;
        chk(restore_req == 1'b0, "R2", "restore ends on done", restore_req, 0);
        cyc(2);
        chk(wr_inh == 1'b0, "R6", "writes open in idle", wr_inh, 0);

        // dirty RAM, falling supply: pulse then save (R5)
        pulse_wr();
        expect_ev(EV_BUSY, "R4");
        expect_ev(EV_SAVE, "R5");
        below_sw = 1'b1;
        while (!save_req) cyc(1);
        chk(busy_pull == 1'b1, "R5", "busy held in save", busy_pull, 1);
        cyc(4);
        save_done = 1'b1; cyc(1); save_done = 1'b0;
        chk(!save_req && !busy_pull, "R5", "save ends on done", save_req, 0);
        // write while low must be ignored (R6)
        chk(wr_inh == 1'b1, "R6", "write inhibit while low", wr_inh, 1);
        pulse_wr();
        below_sw = 1'b0;               // shallow dip: no restore (R3)
        cyc(8);
        chk(!restore_req && !ram_clear, "R3", "no restore after shallow dip", restore_req, 0);

        // clean RAM: pulse only, exact width (R4, R6, R10)
        expect_ev(EV_BUSY, "R4");
        below_sw = 1'b1;
        while (!busy_pull) cyc(1);
        n = 0;
        while (busy_pull) begin n++; cyc(1); end
        chk(n == PULSE, "R4", "busy pulse width", n, PULSE);
        cyc(5);
        chk(save_req == 1'b0, "R6", "inhibited write left RAM clean", save_req, 0);
        below_sw = 1'b0;
        cyc(8);

        // busy line held high: abandon (R8)
        pulse_wr();
        force_hi = 1'b1;
        expect_ev(EV_BUSY, "R8");
        below_sw = 1'b1;
        while (!busy_pull) cyc(1);
        while (busy_pull) cyc(1);
        cyc(5);
        chk(save_req == 1'b0, "R8", "save abandoned", save_req, 0);
        force_hi = 1'b0;
        below_sw = 1'b0;
        cyc(8);

        // still dirty: save timeout (R5), then deep dip restore timeout (R3, R2)
        expect_ev(EV_BUSY, "R4");
        expect_ev(EV_SAVE, "R5");
        below_sw = 1'b1;
        while (!save_req) cyc(1);
        n = 0;
        while (save_req) begin n++; cyc(1); end
        chk(n == SMAX, "R5", "save timeout length", n, SMAX);
        expect_ev(EV_CLEAR, "R3");
        expect_ev(EV_COPY, "R2");
        below_rst = 1'b1;
        cyc(5);
        below_rst = 1'b0;
        below_sw  = 1'b0;
        while (!restore_req) cyc(1);
        n = 0;
        while (restore_req) begin n++; cyc(1); end
        chk(n == RMAX, "R2", "restore timeout length", n, RMAX);
        cyc(3);

        // automatic save disabled (R9), restore cleans RAM (R10)
        pulse_wr();
        auto_off = 1'b1;
        below_sw  = 1'b1;
        below_rst = 1'b1;
        cyc(20);
        chk(!busy_pull && !save_req, "R9", "no auto pulse or save", busy_pull, 0);
        expect_ev(EV_CLEAR, "R1");
        expect_ev(EV_COPY, "R2");
        below_rst = 1'b0;
        below_sw  = 1'b0;
        while (!restore_req) cyc(1);
        cyc(2);
        restore_done = 1'b1; cyc(1); restore_done = 1'b0;
        cyc(2);
        ext_save = 1'b1; cyc(1); ext_save = 1'b0;
        cyc(5);
        chk(save_req == 1'b0, "R10", "restore cleared dirty", save_req, 0);

        // explicit save gated by supply (R7)
        pulse_wr();
        below_sw = 1'b1;
        cyc(5);
        ext_save = 1'b1; cyc(1); ext_save = 1'b0;
        cyc(5);
        chk(save_req == 1'b0, "R7", "explicit save blocked while low", save_req, 0);
        below_sw = 1'b0;
        cyc(8);
        expect_ev(EV_BUSY, "R7");
        expect_ev(EV_SAVE, "R7");
        ext_save = 1'b1; cyc(1); ext_save = 1'b0;
        while (!save_req) cyc(1);
        cyc(2);
        save_done = 1'b1; cyc(1); save_done = 1'b0;
        cyc(3);
        chk(save_req == 1'b0, "R7", "explicit save completed", save_req, 0);

        chk(q.size() == 0, "R1", "all expected events seen", q.size(), 0);
        finish_run();
    end
endmodule